// File: doc/BRIEF.md
# Gate Enable Safety Supervisor

This block decides, cycle by cycle, whether the power stage may fire its gates. It watches a vector of drive fault flags, a vector of supply undervoltage flags, a run-permissive level and a host-serviced watchdog. From these it drives a gate enable, a gate power enable, a pre-charge enable and a host-readable status word.

Each shutdown cause has its own recovery rule. Fault and undervoltage flags are synchronized and then latched, and a soft reset clears them once the cause has gone. A watchdog expiry is sticky: only the power-on reset clears it. Gate power does not follow the run permissive at once. It stays on for half a second after the permissive is withdrawn, and it stays on if the permissive returns before that time has run out.

Top module: `gate_enable_supervisor`

## Requirements
- R1: While `porRstN` is low, and right after it is released with all inputs idle, `gateEn` and `gatePwrEn` are 0, `prechargeEn` is 1 and `statusReg` is 0.
- R2: When any bit of `faultIn` goes high, `gateEn` is 0 after the second rising edge and `statusReg` bit 0 is 1. `prechargeEn` is not affected.
- R3: A fault or undervoltage condition stays latched after its input returns low. `gateEn` stays 0 until a one-cycle `softRst` pulse arrives while the synchronized inputs are low. A `softRst` given while the input is still high does not clear the latch.
- R4: When any bit of `uvIn` goes high, `gateEn` and `prechargeEn` are both 0 after the second rising edge and `statusReg` bit 1 is 1. The latch rule of R3 applies.
- R5: A rising `runPermit` sets `gatePwrEn` after the third rising edge. `gateEn` is 1 only while `gatePwrEn` is 1 and no cause is active or latched.
- R6: After `runPermit` falls, `gatePwrEn` stays 1 for DELAY+1 rising edges and is 0 after the next one, with DELAY = `CLK_FREQ_HZ`/2. `gateEn` drops with it.
- R7: If `runPermit` returns before the delay has expired, the countdown is cancelled and `gatePwrEn` never drops.
- R8: A cycle with `wdogWrEn`=1 and `wdogWrData` = `WDOG_KEY` (default 16'hA5C3) restarts the watchdog. If `WDOG_TIMEOUT_CYC` rising edges pass after the restarting edge with no valid write, the watchdog trips. It is still clear after the edge before that one. A trip forces `gateEn` to 0 and sets `statusReg` bit 11.
- R9: A write whose data differs from `WDOG_KEY` is ignored: the trip time is the same as if that write had not happened.
- R10: A tripped watchdog survives `softRst` and is cleared only by `porRstN`. `statusReg` holds only bits 0, 1 and 11; every other bit is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| porRstN | input | 1 | Asynchronous power-on reset, active low; clears everything including the watchdog trip |
| softRst | input | 1 | Synchronous soft reset; clears the fault and undervoltage latches |
| faultIn | input | N_FAULT | Asynchronous drive fault flags, active high |
| uvIn | input | N_SUPPLY | Asynchronous supply undervoltage flags, active high |
| runPermit | input | 1 | Run permissive level, asynchronous |
| wdogWrEn | input | 1 | Watchdog service write strobe |
| wdogWrData | input | DATA_W | Watchdog service write data |
| gateEn | output | 1 | Gate firing allowed |
| gatePwrEn | output | 1 | Gate driver power enable |
| prechargeEn | output | 1 | Pre-charge enable |
| statusReg | output | STATUS_W | Status: bit 0 fault, bit 1 undervoltage, bit 11 watchdog tripped |

## Verification
A vector table drives the main gating function with several input patterns. These are idle inputs, a single fault at either end of the fault vector, a single undervoltage flag at either end of the supply vector, mixed fault and undervoltage, and everything set at once. Together they show whether the fault path leaves pre-charge alone while the undervoltage path removes it, and whether each cause lands in its own status bit. After each pattern the bench checks that the latch holds once the input has cleared, and that a soft reset then releases it. Directed sequences then cover the edge-exact gate power delay and its cancellation, the watchdog trip edge with a valid key and with a wrong key, and the watchdog trip surviving a soft reset.

// File: rtl/gsup_pkg.sv
package gsup_pkg;

  // Strobes from control to datapath
  typedef struct packed {
    logic wdKick;    // valid watchdog service this cycle
    logic wdFreeze;  // watchdog tripped, hold counter
    logic dlyClear;  // hold gate power delay counter at zero
  } ctlStrobe_t;

  // Conditioned state from datapath to control
  typedef struct packed {
    logic faultNow;
    logic uvNow;
    logic runNow;
    logic wdExpire;
    logic delayDone;
  } dpStat_t;

  localparam int FAULT_BIT = 0;
  localparam int UV_BIT    = 1;
  localparam int WDOG_BIT  = 11;

endpackage

// File: rtl/gsup_sync.sv
module gsup_sync #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         porRstN,
  input  logic [W-1:0] asyncIn,
  output logic [W-1:0] syncOut
);
  logic [W-1:0] stage1;

  always_ff @(posedge clk or negedge porRstN) begin
    if (!porRstN) begin
      stage1  <= '0;
      syncOut <= '0;
    end else begin
      stage1  <= asyncIn;
      syncOut <= stage1;
    end
  end
endmodule

// File: rtl/gsup_datapath.sv
module gsup_datapath
  import gsup_pkg::*;
#(
  parameter int N_FAULT          = 4,
  parameter int N_SUPPLY         = 3,
  parameter int DELAY_CYC        = 50_000_000,
  parameter int WDOG_TIMEOUT_CYC = 1_000_000
) (
  input  logic                clk,
  input  logic                porRstN,
  input  logic [N_FAULT-1:0]  faultIn,
  input  logic [N_SUPPLY-1:0] uvIn,
  input  logic                runPermit,
  input  ctlStrobe_t          strobe,
  output dpStat_t             dpStat
);
  localparam int DLY_W  = $clog2(DELAY_CYC + 1);
  localparam int WD_W   = $clog2(WDOG_TIMEOUT_CYC + 1);
  localparam int N_SYNC = N_FAULT + N_SUPPLY + 1;

  logic [N_SYNC-1:0] rawVec, syncVec;
  logic [DLY_W-1:0]  dlyCnt;
  logic [WD_W-1:0]   wdCnt;
  logic              dlyAtEnd, wdAtEnd;

  assign rawVec = {runPermit, uvIn, faultIn};

  gsup_sync #(.W(N_SYNC)) sync_i (
    .clk     (clk),
    .porRstN (porRstN),
    .asyncIn (rawVec),
    .syncOut (syncVec)
  );

  assign dlyAtEnd = (dlyCnt == DLY_W'(DELAY_CYC - 1));
  assign wdAtEnd  = (wdCnt == WD_W'(WDOG_TIMEOUT_CYC - 1));

  // Gate power off-delay counter
  always_ff @(posedge clk or negedge porRstN) begin
    if (!porRstN)            dlyCnt <= '0;
    else if (strobe.dlyClear) dlyCnt <= '0;
    else if (!dlyAtEnd)      dlyCnt <= dlyCnt + 1'b1;
  end

  // Watchdog interval counter
  always_ff @(posedge clk or negedge porRstN) begin
    if (!porRstN)             wdCnt <= '0;
    else if (strobe.wdFreeze) wdCnt <= wdCnt;
    else if (strobe.wdKick)   wdCnt <= '0;
    else if (!wdAtEnd)        wdCnt <= wdCnt + 1'b1;
  end

  always_comb begin
    dpStat.faultNow  = |syncVec[N_FAULT-1:0];
    dpStat.uvNow     = |syncVec[N_FAULT +: N_SUPPLY];
    dpStat.runNow    = syncVec[N_SYNC-1];
    dpStat.delayDone = dlyAtEnd;
    dpStat.wdExpire  = wdAtEnd && !strobe.wdKick && !strobe.wdFreeze;
  end

  AST_DELAY_CLEARED: assert property (@(posedge clk) disable iff (!porRstN)
    strobe.dlyClear |=> !dpStat.delayDone || (DELAY_CYC == 1)); // R7

endmodule

// File: rtl/gsup_control.sv
module gsup_control
  import gsup_pkg::*;
#(
  parameter int              DATA_W           = 16,
  parameter logic [DATA_W-1:0] WDOG_KEY       = 16'hA5C3,
  parameter int              STATUS_W         = 16,
  parameter int              WDOG_TIMEOUT_CYC = 1_000_000
) (
  input  logic              clk,
  input  logic              porRstN,
  input  logic              softRst,
  input  logic              wdogWrEn,
  input  logic [DATA_W-1:0] wdogWrData,
  input  dpStat_t           dpStat,
  output ctlStrobe_t        strobe,
  output logic              gateEn,
  output logic              gatePwrEn,
  output logic              prechargeEn,
  output logic [STATUS_W-1:0] statusReg
);
  logic faultLatch, uvLatch, wdogTrip, gatePwrOn;
  logic faultAny, uvAny;

  generate
    if (STATUS_W <= WDOG_BIT) begin : g_badWidth
      initial $error("STATUS_W must exceed the watchdog status bit index");
    end
  endgenerate

  assign faultAny = faultLatch || dpStat.faultNow;
  assign uvAny    = uvLatch || dpStat.uvNow;

  // Fault and undervoltage latches: soft reset reloads them from the live cause
  always_ff @(posedge clk or negedge porRstN) begin
    if (!porRstN) begin
      faultLatch <= 1'b0;
      uvLatch    <= 1'b0;
    end else if (softRst) begin
      faultLatch <= dpStat.faultNow;
      uvLatch    <= dpStat.uvNow;
    end else begin
      faultLatch <= faultAny;
      uvLatch    <= uvAny;
    end
  end

  // Watchdog trip: cleared by power-on reset only
  always_ff @(posedge clk or negedge porRstN) begin
    if (!porRstN)             wdogTrip <= 1'b0;
    else if (dpStat.wdExpire) wdogTrip <= 1'b1;
  end

  // Gate power with off-delay
  always_ff @(posedge clk or negedge porRstN) begin
    if (!porRstN)              gatePwrOn <= 1'b0;
    else if (dpStat.runNow)    gatePwrOn <= 1'b1;
    else if (dpStat.delayDone) gatePwrOn <= 1'b0;
  end

  always_comb begin
    strobe.wdKick   = wdogWrEn && (wdogWrData == WDOG_KEY);
    strobe.wdFreeze = wdogTrip;
    strobe.dlyClear = dpStat.runNow || !gatePwrOn;
  end

  assign gatePwrEn   = gatePwrOn;
  assign gateEn      = gatePwrOn && !faultAny && !uvAny && !wdogTrip;
  assign prechargeEn = !uvAny;

  always_comb begin
    statusReg            = '0;
    statusReg[FAULT_BIT] = faultAny;
    statusReg[UV_BIT]    = uvAny;
    statusReg[WDOG_BIT]  = wdogTrip;
  end

  AST_WDOG_STICKY: assert property (@(posedge clk) disable iff (!porRstN)
    wdogTrip |=> wdogTrip); // R10

  AST_KICK_DEFERS_TRIP: assert property (@(posedge clk) disable iff (!porRstN)
    (strobe.wdKick && !wdogTrip) |=> (!dpStat.wdExpire || (WDOG_TIMEOUT_CYC == 1))); // R8

  AST_PWR_HELD_BY_RUN: assert property (@(posedge clk) disable iff (!porRstN)
    dpStat.runNow |=> gatePwrOn); // R7

  AST_PWR_DROP_AFTER_DELAY: assert property (@(posedge clk) disable iff (!porRstN)
    $fell(gatePwrOn) |-> $past(dpStat.delayDone)); // R6

  AST_FAULT_LATCHES: assert property (@(posedge clk) disable iff (!porRstN)
    (dpStat.faultNow && !softRst) |=> faultLatch); // R3

endmodule

// File: rtl/gate_enable_supervisor.sv
module gate_enable_supervisor
  import gsup_pkg::*;
#(
  parameter int                N_FAULT          = 4,
  parameter int                N_SUPPLY         = 3,
  parameter int                DATA_W           = 16,
  parameter logic [DATA_W-1:0] WDOG_KEY         = 16'hA5C3,
  parameter int                STATUS_W         = 16,
  parameter int                CLK_FREQ_HZ      = 100_000_000,
  parameter int                WDOG_TIMEOUT_CYC = 1_000_000
) (
  input  logic                clk,
  input  logic                porRstN,
  input  logic                softRst,
  input  logic [N_FAULT-1:0]  faultIn,
  input  logic [N_SUPPLY-1:0] uvIn,
  input  logic                runPermit,
  input  logic                wdogWrEn,
  input  logic [DATA_W-1:0]   wdogWrData,
  output logic                gateEn,
  output logic                gatePwrEn,
  output logic                prechargeEn,
  output logic [STATUS_W-1:0] statusReg
);
  localparam int DELAY_CYC = CLK_FREQ_HZ / 2;

  ctlStrobe_t strobe;
  dpStat_t    dpStat;

  gsup_datapath #(
    .N_FAULT          (N_FAULT),
    .N_SUPPLY         (N_SUPPLY),
    .DELAY_CYC        (DELAY_CYC),
    .WDOG_TIMEOUT_CYC (WDOG_TIMEOUT_CYC)
  ) datapath_i (
    .clk       (clk),
    .porRstN   (porRstN),
    .faultIn   (faultIn),
    .uvIn      (uvIn),
    .runPermit (runPermit),
    .strobe    (strobe),
    .dpStat    (dpStat)
  );

  gsup_control #(
    .DATA_W           (DATA_W),
    .WDOG_KEY         (WDOG_KEY),
    .STATUS_W         (STATUS_W),
    .WDOG_TIMEOUT_CYC (WDOG_TIMEOUT_CYC)
  ) control_i (
    .clk         (clk),
    .porRstN     (porRstN),
    .softRst     (softRst),
    .wdogWrEn    (wdogWrEn),
    .wdogWrData  (wdogWrData),
    .dpStat      (dpStat),
    .strobe      (strobe),
    .gateEn      (gateEn),
    .gatePwrEn   (gatePwrEn),
    .prechargeEn (prechargeEn),
    .statusReg   (statusReg)
  );

  AST_GATE_NEEDS_POWER: assert property (@(posedge clk) disable iff (!porRstN)
    gateEn |-> gatePwrEn); // R5

  AST_UV_BLOCKS_PRECHARGE: assert property (@(posedge clk) disable iff (!porRstN)
    dpStat.uvNow |-> (!prechargeEn && !gateEn)); // R4

  AST_FAULT_BLOCKS_GATE: assert property (@(posedge clk) disable iff (!porRstN)
    dpStat.faultNow |-> !gateEn); // R2

endmodule

// File: tb/gate_enable_supervisor_tb.sv
module gate_enable_supervisor_tb_top;
  localparam int          N_FAULT  = 4;
  localparam int          N_SUPPLY = 3;
  localparam int          DATA_W   = 16;
  localparam logic [15:0] KEY      = 16'hA5C3;
  localparam int          FREQ     = 200;
  localparam int          DELAY    = FREQ / 2;
  localparam int          TMO      = 400;

  // {fault[3:0], uv[2:0], expGate, expPre, expUvBit, expFaultBit}
  localparam logic [10:0] VECS [8] = '{
    11'b0000_000_1_1_0_0,
    11'b0001_000_0_1_0_1,
    11'b1000_000_0_1_0_1,
    11'b0000_001_0_0_1_0,
    11'b0000_100_0_0_1_0,
    11'b0110_010_0_0_1_1,
    11'b1111_111_0_0_1_1,
    11'b0100_000_0_1_0_1
  };

  logic clk = 1'b0;
  logic porRstN, softRst, runPermit, wdogWrEn;
  logic [N_FAULT-1:0]  faultIn;
  logic [N_SUPPLY-1:0] uvIn;
  logic [DATA_W-1:0]   wdogWrData;
  logic gateEn, gatePwrEn, prechargeEn;
  logic [15:0] statusReg;

  int checks = 0;
  int fails  = 0;
  int kickCnt = 0;
  bit autoKick = 1'b1;
  bit done = 1'b0;

  always #5 clk = ~clk;

  gate_enable_supervisor #(
    .N_FAULT(N_FAULT), .N_SUPPLY(N_SUPPLY), .DATA_W(DATA_W), .WDOG_KEY(KEY),
    .STATUS_W(16), .CLK_FREQ_HZ(FREQ), .WDOG_TIMEOUT_CYC(TMO)
  ) dut_i (
    .clk(clk), .porRstN(porRstN), .softRst(softRst), .faultIn(faultIn),
    .uvIn(uvIn), .runPermit(runPermit), .wdogWrEn(wdogWrEn),
    .wdogWrData(wdogWrData), .gateEn(gateEn), .gatePwrEn(gatePwrEn),
    .prechargeEn(prechargeEn), .statusReg(statusReg)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h t=%0t", req, act, exp, $time);
    end
  endtask

  // n rising edges, ending at a falling edge; services the watchdog when enabled
  task automatic tick(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      @(negedge clk);
      if (autoKick) begin
        kickCnt++;
        wdogWrEn   = (kickCnt % 50 == 0);
        wdogWrData = KEY;
      end
    end
  endtask

  task automatic pulseSoft();
    softRst = 1'b1;
    tick(1);
    softRst = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog act=running exp=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    porRstN = 1'b0; softRst = 1'b0; runPermit = 1'b0; wdogWrEn = 1'b0;
    wdogWrData = '0; faultIn = '0; uvIn = '0;
    @(negedge clk);
    tick(2);
    chk("R1 gateEn in reset", gateEn, 0);
    chk("R1 gatePwrEn in reset", gatePwrEn, 0);
    chk("R1 prechargeEn in reset", prechargeEn, 1);
    chk("R1 status in reset", statusReg, 0);
    porRstN = 1'b1;
    tick(1);
    chk("R1 gateEn after reset", gateEn, 0);
    chk("R1 status after reset", statusReg, 0);

    // R5 run permissive brings gate power up on the third edge
    runPermit = 1'b1;
    tick(2);
    chk("R5 gatePwrEn before third edge", gatePwrEn, 0);
    tick(1);
    chk("R5 gatePwrEn after third edge", gatePwrEn, 1);
    chk("R5 gateEn with power, no cause", gateEn, 1);

    // R2 R4 R3 vector walk
    for (int v = 0; v < 8; v++) begin
      faultIn = VECS[v][10:7];
      uvIn    = VECS[v][6:4];
      tick(2);
      chk("R2/R4 gateEn", gateEn, VECS[v][3]);
      chk("R4 prechargeEn", prechargeEn, VECS[v][2]);
      chk("R2/R4 status", statusReg, {14'd0, VECS[v][1:0]});
      faultIn = '0; uvIn = '0;
      tick(3);
      chk("R3 latched gateEn", gateEn, VECS[v][3]);
      chk("R3 latched status", statusReg, {14'd0, VECS[v][1:0]});
      pulseSoft();
      chk("R3 gateEn after soft reset", gateEn, 1);
      chk("R3 prechargeEn after soft reset", prechargeEn, 1);
    end

    // R3 soft reset while fault still active does not clear
    faultIn = 4'b0010;
    tick(3);
    pulseSoft();
    chk("R3 soft reset with fault active", gateEn, 0);
    faultIn = '0;
    tick(3);
    chk("R3 still latched", statusReg, 16'h0001);
    pulseSoft();
    chk("R3 cleared after fault gone", gateEn, 1);

    // R7 short permissive dropout cancels the countdown
    runPermit = 1'b0;
    tick(DELAY / 2);
    chk("R7 power held mid-delay", gatePwrEn, 1);
    runPermit = 1'b1;
    tick(DELAY);
    chk("R7 power still on after re-assert", gatePwrEn, 1);
    chk("R7 gateEn still on", gateEn, 1);

    // R6 full off-delay
    runPermit = 1'b0;
    tick(DELAY + 1);
    chk("R6 power on at DELAY+1 edges", gatePwrEn, 1);
    tick(1);
    chk("R6 power off at DELAY+2 edges", gatePwrEn, 0);
    chk("R6 gateEn off with power", gateEn, 0);
    runPermit = 1'b1;
    tick(3);
    chk("R5 power back", gatePwrEn, 1);

    // R8 watchdog trip edge after a valid key
    autoKick = 1'b0;
    wdogWrEn = 1'b1; wdogWrData = KEY;
    tick(1);
    wdogWrEn = 1'b0;
    tick(TMO - 1);
    chk("R8 no trip one edge early", statusReg, 0);
    chk("R8 gateEn before trip", gateEn, 1);
    tick(1);
    chk("R8 trip status bit 11", statusReg, 16'h0800);
    chk("R8 gateEn after trip", gateEn, 0);

    // R10 soft reset does not clear the trip, power-on reset does
    pulseSoft();
    chk("R10 trip survives soft reset", statusReg, 16'h0800);
    chk("R10 gateEn after soft reset", gateEn, 0);
    porRstN = 1'b0;
    tick(1);
    porRstN = 1'b1;
    chk("R10 trip cleared by power-on reset", statusReg, 0);
    tick(3);

    // R9 wrong key is ignored
    wdogWrEn = 1'b1; wdogWrData = KEY;
    tick(1);
    wdogWrEn = 1'b0;
    tick(10);
    wdogWrEn = 1'b1; wdogWrData = 16'h1234;
    tick(1);
    wdogWrEn = 1'b0;
    tick(TMO - 12);
    chk("R9 no trip one edge early", statusReg, 0);
    tick(1);
    chk("R9 wrong key did not restart", statusReg, 16'h0800);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule